// File: doc/BRIEF.md
# Condition Flag Register with Inverted Operand-Bus Readout

This block holds the four processor condition flags (negative, zero, carry, overflow) in storage kept apart from the general register file. The flags take new values in one of two ways. A full load copies the top four bits of the ALU result bus. A condition update takes negative, zero and overflow from the ALU, and takes carry from either the ALU or the shifter, chosen by a select input.

Readout uses only the second operand bus. That bus is precharged and carries inverted data: an idle line rests at 1, and a driver signals a data 1 by pulling its line to 0. The two clock phases are modelled by a `phase1` input. While `phase1` is low (phase 2) the bus sits at its precharge value. While `phase1` is high, drivers may pull lines low. The flag output enable turns on in phase 1 in two cases: decode asks for a trap-entry save, or decode enables the second operand bus while the register file reports that this port is reading the PC. When the PC word is read on the first operand bus, neither of these conditions holds, so no flags appear there.

The bus is modelled as a wired AND. Each line equals the precharge value with every pull-down removed, whether the pull-down comes from this block or from the other drivers collected on `ext_pull`. Because the port is plain control with no data stream, there is no valid/ready handshake, and every input is sampled on every cycle.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all four flags to 0 at the next rising clock edge.
- R2: When `wr_bus_en` is 1, the next edge loads the flags from `res_bus`: N from bit 31, Z from bit 30, C from bit 29, V from bit 28. `flags_out` shows them in the order {N,Z,C,V}, with N at bit 3.
- R3: When `cond_upd_en` is 1 and `wr_bus_en` is 0, the next edge loads N, Z and V from `alu_n`, `alu_z` and `alu_v`. C is loaded from `sh_c` when `c_from_shifter` is 1, and from `alu_c` otherwise.
- R4: When `wr_bus_en` and `cond_upd_en` are both 1, the bus load wins.
- R5: When both enables are 0, the flags keep their value, whatever is on `res_bus` or the condition inputs.
- R6: `flag_oe` is 1 exactly when `phase1` is 1 and either `trap_save_en` is 1, or both `b_read_en` and `b_is_pc` are 1.
- R7: While `phase1` is 0, every bit of `b_bus_n` is 1 (precharge), whatever the other inputs are.
- R8: While `flag_oe` is 1, bus bits 31..28 carry the inverted flags (N on bit 31, down to V on bit 28), so a flag of 1 reads as 0. Bits 27..0 are not driven by this block.
- R9: In phase 1 with `flag_oe` at 0, this block pulls no line, so `b_bus_n` equals the inverse of `ext_pull`.
- R10: In phase 1, a line reads 0 if this block or `ext_pull` pulls it, and 1 only if neither does (wired AND).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase1 | input | 1 | 1 = phase 1 (drive window), 0 = phase 2 (precharge) |
| res_bus | input | 32 | ALU result bus; bits 31..28 feed a full flag load |
| wr_bus_en | input | 1 | Load the flags from the result bus |
| cond_upd_en | input | 1 | Load the flags from the condition outputs |
| alu_n | input | 1 | ALU negative output |
| alu_z | input | 1 | ALU zero output |
| alu_c | input | 1 | ALU carry output |
| alu_v | input | 1 | ALU overflow output |
| sh_c | input | 1 | Shifter carry-out |
| c_from_shifter | input | 1 | 1 = carry comes from the shifter |
| trap_save_en | input | 1 | Decode request to save the flags at trap entry |
| b_read_en | input | 1 | Decode enable of the second operand bus |
| b_is_pc | input | 1 | Register file reports that the second port addresses the PC |
| ext_pull | input | 32 | Pull-down requests from the other bus drivers (1 = pull low) |
| flags_out | output | 4 | Stored flags {N,Z,C,V} |
| flag_oe | output | 1 | Flag output enable |
| b_bus_n | output | 32 | Second operand bus, inverted data |

## Verification
The assertions assume that `rst` is held high for at least one edge before checking begins. They also assume that every input stays stable from one falling edge to the next, so the value sampled at a rising edge is the one that produced the visible bus. The driver changes inputs only on falling edges, applies one full set of inputs per cycle, and keeps `ext_pull` at zero wherever a check reads the flag lines alone. It then turns on external pulls on purpose, both on flag lines and on other lines, to exercise the wired AND.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int unsigned NUM_FLAGS = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/flag_cond_mux.sv
module flag_cond_mux
  import cfu_pkg::*;
(
  input  logic   alu_n,
  input  logic   alu_z,
  input  logic   alu_c,
  input  logic   alu_v,
  input  logic   sh_c,
  input  logic   c_from_shifter,
  output flags_t cond
);
  always_comb begin
    cond.n = alu_n;
    cond.z = alu_z;
    cond.c = c_from_shifter ? sh_c : alu_c;
    cond.v = alu_v;
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import cfu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_bus_en,
  input  flags_t bus_val,
  input  logic   cond_upd_en,
  input  flags_t cond_val,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)              q <= '0;
    else if (wr_bus_en)   q <= bus_val;
    else if (cond_upd_en) q <= cond_val;
  end
endmodule

// File: rtl/flag_oe_gate.sv
module flag_oe_gate (
  input  logic phase1,
  input  logic trap_save_en,
  input  logic b_read_en,
  input  logic b_is_pc,
  output logic oe
);
  logic pc_read_b;
  assign pc_read_b = b_read_en & b_is_pc;
  assign oe        = phase1 & (trap_save_en | pc_read_b);
endmodule

// File: rtl/flag_bus_drive.sv
module flag_bus_drive
  import cfu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FLAG_LSB = 28
) (
  input  logic              phase1,
  input  logic              oe,
  input  flags_t            flags,
  input  logic [DATA_W-1:0] ext_pull,
  output logic [DATA_W-1:0] bus_n
);
  logic [NUM_FLAGS-1:0] fvec;
  logic [DATA_W-1:0]    self_pull;

  assign fvec = flags;

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    if (i >= FLAG_LSB) begin : g_flag
      assign self_pull[i] = oe & fvec[i-FLAG_LSB];
    end else begin : g_idle
      assign self_pull[i] = 1'b0;
    end
  end

  assign bus_n = phase1 ? ~(ext_pull | self_pull) : {DATA_W{1'b1}};
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase1,
  input  logic [DATA_W-1:0]    res_bus,
  input  logic                 wr_bus_en,
  input  logic                 cond_upd_en,
  input  logic                 alu_n,
  input  logic                 alu_z,
  input  logic                 alu_c,
  input  logic                 alu_v,
  input  logic                 sh_c,
  input  logic                 c_from_shifter,
  input  logic                 trap_save_en,
  input  logic                 b_read_en,
  input  logic                 b_is_pc,
  input  logic [DATA_W-1:0]    ext_pull,
  output logic [NUM_FLAGS-1:0] flags_out,
  output logic                 flag_oe,
  output logic [DATA_W-1:0]    b_bus_n
);
  localparam int unsigned FLAG_LSB = DATA_W - NUM_FLAGS;

  flags_t cond_val, bus_val, q;

  assign bus_val = flags_t'(res_bus[DATA_W-1:FLAG_LSB]);

  flag_cond_mux u_cmux (
    .alu_n(alu_n), .alu_z(alu_z), .alu_c(alu_c), .alu_v(alu_v),
    .sh_c(sh_c), .c_from_shifter(c_from_shifter), .cond(cond_val)
  );

  flag_store u_store (
    .clk(clk), .rst(rst), .wr_bus_en(wr_bus_en), .bus_val(bus_val),
    .cond_upd_en(cond_upd_en), .cond_val(cond_val), .q(q)
  );

  flag_oe_gate u_gate (
    .phase1(phase1), .trap_save_en(trap_save_en), .b_read_en(b_read_en),
    .b_is_pc(b_is_pc), .oe(flag_oe)
  );

  flag_bus_drive #(.DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB)) u_drive (
    .phase1(phase1), .oe(flag_oe), .flags(q), .ext_pull(ext_pull),
    .bus_n(b_bus_n)
  );

  assign flags_out = q;
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              phase1,
  input logic [DATA_W-1:0] res_bus,
  input logic              wr_bus_en,
  input logic              cond_upd_en,
  input logic              alu_n,
  input logic              alu_z,
  input logic              alu_c,
  input logic              alu_v,
  input logic              sh_c,
  input logic              c_from_shifter,
  input logic              trap_save_en,
  input logic              b_read_en,
  input logic              b_is_pc,
  input logic [DATA_W-1:0] ext_pull,
  input logic [3:0]        flags_out,
  input logic              flag_oe,
  input logic [DATA_W-1:0] b_bus_n
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> flags_out == 4'b0000);

  a_r2_bus_load: assert property (@(posedge clk) disable iff (rst)
    wr_bus_en |=> flags_out == $past(res_bus[DATA_W-1:DATA_W-4]));

  a_r3_cond_load: assert property (@(posedge clk) disable iff (rst)
    (cond_upd_en && !wr_bus_en) |=> flags_out ==
      {$past(alu_n), $past(alu_z),
       ($past(c_from_shifter) ? $past(sh_c) : $past(alu_c)), $past(alu_v)});

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_bus_en && !cond_upd_en) |=> $stable(flags_out));

  a_r6_oe_phase: assert property (@(posedge clk) disable iff (rst)
    flag_oe |-> (phase1 && (trap_save_en || (b_read_en && b_is_pc))));

  a_r7_precharge: assert property (@(posedge clk) disable iff (rst)
    !phase1 |-> b_bus_n == {DATA_W{1'b1}});

  a_r9_no_drive: assert property (@(posedge clk) disable iff (rst)
    (phase1 && !flag_oe) |-> b_bus_n == ~ext_pull);

  a_r8_flag_lines: assert property (@(posedge clk) disable iff (rst)
    flag_oe |-> b_bus_n[DATA_W-1:DATA_W-4] ==
      ~(flags_out | ext_pull[DATA_W-1:DATA_W-4]));
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .phase1(phase1), .res_bus(res_bus),
  .wr_bus_en(wr_bus_en), .cond_upd_en(cond_upd_en), .alu_n(alu_n),
  .alu_z(alu_z), .alu_c(alu_c), .alu_v(alu_v), .sh_c(sh_c),
  .c_from_shifter(c_from_shifter), .trap_save_en(trap_save_en),
  .b_read_en(b_read_en), .b_is_pc(b_is_pc), .ext_pull(ext_pull),
  .flags_out(flags_out), .flag_oe(flag_oe), .b_bus_n(b_bus_n)
);

// File: tb/cond_flag_unit_test.sv
module cond_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase1 = 1'b0;
  logic [31:0] res_bus = '0;
  logic        wr_bus_en = 1'b0, cond_upd_en = 1'b0;
  logic        alu_n = 1'b0, alu_z = 1'b0, alu_c = 1'b0, alu_v = 1'b0;
  logic        sh_c = 1'b0, c_from_shifter = 1'b0;
  logic        trap_save_en = 1'b0, b_read_en = 1'b0, b_is_pc = 1'b0;
  logic [31:0] ext_pull = '0;
  logic [3:0]  flags_out;
  logic        flag_oe;
  logic [31:0] b_bus_n;

  always #4 clk = ~clk;

  cond_flag_unit uut (
    .clk(clk), .rst(rst), .phase1(phase1), .res_bus(res_bus),
    .wr_bus_en(wr_bus_en), .cond_upd_en(cond_upd_en), .alu_n(alu_n),
    .alu_z(alu_z), .alu_c(alu_c), .alu_v(alu_v), .sh_c(sh_c),
    .c_from_shifter(c_from_shifter), .trap_save_en(trap_save_en),
    .b_read_en(b_read_en), .b_is_pc(b_is_pc), .ext_pull(ext_pull),
    .flags_out(flags_out), .flag_oe(flag_oe), .b_bus_n(b_bus_n)
  );

  typedef struct {
    string       req;
    logic [3:0]  flags;
    logic        oe;
    logic [31:0] bus;
  } item_t;

  item_t      sb[$];
  logic [3:0] mf = 4'b0000;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  // Driver: one cycle of stimulus, expected outcome pushed to the scoreboard.
  task automatic go(input string req, input logic r, input logic ph,
                    input logic wr, input logic cu, input logic [31:0] res,
                    input logic [3:0] alu, input logic shc, input logic csel,
                    input logic trap, input logic bre, input logic bpc,
                    input logic [31:0] ext);
    item_t it;
    logic  oe;
    logic [31:0] pull;
    @(negedge clk);
    rst = r; phase1 = ph; wr_bus_en = wr; cond_upd_en = cu; res_bus = res;
    {alu_n, alu_z, alu_c, alu_v} = alu; sh_c = shc; c_from_shifter = csel;
    trap_save_en = trap; b_read_en = bre; b_is_pc = bpc; ext_pull = ext;
    if (r)       mf = 4'b0000;
    else if (wr) mf = res[31:28];
    else if (cu) mf = {alu[3], alu[2], (csel ? shc : alu[1]), alu[0]};
    oe   = ph & (trap | (bre & bpc));
    pull = ext | (oe ? {mf, 28'h0} : 32'h0);
    it.req = req; it.flags = mf; it.oe = oe;
    it.bus = ph ? ~pull : 32'hFFFF_FFFF;
    sb.push_back(it);
  endtask

  // Monitor: sample between the rising and the falling edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_cmp++;
      if (flags_out !== e.flags || flag_oe !== e.oe || b_bus_n !== e.bus) begin
        n_bad++;
        $display("FAIL %s: flags=%b oe=%b bus=%h expected flags=%b oe=%b bus=%h",
                 e.req, flags_out, flag_oe, b_bus_n, e.flags, e.oe, e.bus);
      end
    end
  end

  initial begin
    #(64'd8 * 64'd200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    //   req    rst ph wr cu res           alu     shc csel trp bre bpc ext
    go("R1",   1, 1, 0, 0, 32'hF000_0000, 4'hF,  1, 0,  1,  0,  0,  32'h0);
    go("R1",   1, 1, 1, 1, 32'hF000_0000, 4'hF,  1, 0,  1,  0,  0,  32'h0);
    // R2 load 1010 while in phase 2: R7 keeps the bus precharged
    go("R2",   0, 0, 1, 0, 32'hA123_4567, 4'h0,  0, 0,  1,  1,  1,  32'h0000_FFFF);
    go("R8 trap read", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 1, 0, 0, 32'h0);
    go("R6 pc read on B", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 0, 1, 1, 32'h0);
    go("R9 B enable without pc", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 0, 1, 0, 32'h0000_00F0);
    go("R9 pc without B enable", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0, 1, 32'h1234_0000);
    go("R7 phase2 with oe request", 0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF);
    // R3: alu 0101 with alu_c=0, carry from ALU
    go("R3 alu carry", 0, 1, 0, 1, 32'hFFFF_FFFF, 4'b0101, 1, 0, 1, 0, 0, 32'h0);
    // R3: alu_c=0 but shifter carry 1 selected
    go("R3 shifter carry", 0, 1, 0, 1, 32'h0, 4'b1000, 1, 1, 1, 0, 0, 32'h0);
    go("R3 shifter carry 0", 0, 1, 0, 1, 32'h0, 4'b0110, 0, 1, 0, 1, 1, 32'h0);
    // R4: both enables, bus 0011 wins over alu 1100
    go("R4", 0, 1, 1, 1, 32'h3000_0000, 4'b1100, 1, 0, 1, 0, 0, 32'h0);
    // R5: hold with noisy inputs
    go("R5", 0, 1, 0, 0, 32'hFFFF_FFFF, 4'hF, 1, 1, 1, 0, 0, 32'h0);
    go("R5", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 1, 0, 0, 32'h0);
    // R10: flags 0011; external pulls on bit 31 and bit 29 and low bits
    go("R10", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 1, 0, 0, 32'hA000_0003);
    go("R2 load 1111", 0, 1, 1, 0, 32'hF000_0000, 4'h0, 0, 0, 0, 1, 1, 32'h0);
    go("R10 no flag drive", 0, 1, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0, 0, 32'h5000_0001);
    go("R1 mid-run reset", 1, 1, 0, 0, 32'h0, 4'h0, 0, 0, 1, 0, 0, 32'h0);
    go("R2 load 0001", 0, 1, 1, 0, 32'h1FFF_FFFF, 4'h0, 0, 0, 1, 0, 0, 32'h0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule